// File: doc/BRIEF.md
# Encrypted Region Access Classifier

This block sits beside the read-address channel of a memory port that serves encrypted, read-only content. Each accepted address is compared against four programmable windows. The result tells the read-data path three things: whether the beat must be decrypted, which window's key context to use, and whether the data must be forced to zero. Data must be forced to zero when the access type breaks the window's fetch policy. A policy breach also raises a one-cycle pulse and a sticky error flag that software can clear.

Windows are compared in units of 4 KB pages. Only address bits 27:12 take part in the comparison. A window covers every page from its start page up to its end page, both ends included. A window counts only when it is enabled and its end page is strictly above its start page. If two windows overlap, the lowest-numbered one wins, so the result stays deterministic. The comparison is combinational in the cycle the request is valid, and the result is registered once for use on the data channel. A small readback port returns a window's bounds in the form software sees them.

Top module: `enc_region_classifier`

## Requirements
- R1: One clock edge after a cycle with `req_valid` high, `rd_hit` is 1 and `rd_region` holds the window index when the address page lies within an enabled, valid window. The start and end pages both count as inside.
- R2: Address bits 31:28 and 11:0, of both the request and the window bounds, have no effect on matching.
- R3: A window that is disabled, or whose end page is not above its start page, never matches. On a miss, `rd_hit`, `rd_region` and `rd_zero` are all 0, which means the data passes through unchanged.
- R4: When several windows match, `rd_region` is the lowest matching index.
- R5: Mode 2'b01 permits data reads only. An instruction fetch (`req_fetch`=1) into such a window is a violation.
- R6: Modes 2'b00 and 2'b11 permit fetches only, so a data read into such a window is a violation. Mode 2'b10 permits both kinds of access.
- R7: A violating request sets `rd_zero`=1 and `rd_hit`=1, and raises `viol_pulse` for exactly one cycle.
- R8: `viol_sticky` sets on a violation and stays set until `err_clear`. If a violation and `err_clear` arrive in the same cycle, the flag stays set.
- R9: In a cycle with `req_valid` low, `rd_hit`, `rd_region` and `rd_zero` hold their values and `viol_pulse` is 0.
- R10: `rb_start` returns the selected start address with bits 31:28 and 11:0 reading zero. `rb_end` returns the selected end address with bits 31:28 zero and bits 11:0 reading one.
- R11: While reset is asserted, and right after it, all registered outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read address valid this cycle |
| req_addr | input | 32 | Read address |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data read |
| cfg_start | input | 128 | Window start addresses, window i in bits 32i+31:32i |
| cfg_end | input | 128 | Window end addresses, same packing |
| cfg_en | input | 4 | Window enables |
| cfg_mode | input | 8 | Window modes, window i in bits 2i+1:2i |
| err_clear | input | 1 | Clears the sticky violation flag |
| rb_sel | input | 2 | Window selected for readback |
| rd_hit | output | 1 | Registered: request falls in an encrypted window |
| rd_region | output | 2 | Registered: winning window index |
| rd_zero | output | 1 | Registered: data must be forced to zero |
| viol_pulse | output | 1 | One-cycle policy violation pulse |
| viol_sticky | output | 1 | Sticky policy violation flag |
| rb_start | output | 32 | Masked start address of the selected window |
| rb_end | output | 32 | Masked end address of the selected window |

## Verification
The bench probes the page just before each window's start, the start page, the end page and the page just after the end, with both access types. An off-by-one in the bound comparison shows up there as a hit on a neighbour page or a miss on the first or last page of a window. Windows with a single page, with the end below the start, or disabled would match wrongly if the validity rule were dropped. Overlapping windows expose a priority picker that chooses the highest index. Addresses with their top nibble set catch a comparison that uses the full address. A clear that arrives in the same cycle as a violation catches a sticky flag whose clear wins over its set.

// File: rtl/enc_cls_pkg.sv
package enc_cls_pkg;

   typedef enum logic [1:0] {
      MODE_FETCH_A = 2'b00,
      MODE_DATA    = 2'b01,
      MODE_BOTH    = 2'b10,
      MODE_FETCH_B = 2'b11
   } win_mode_e;

   // 1 when the access kind is forbidden by the window mode
   function automatic logic mode_breach(input win_mode_e m, input logic is_fetch);
      case (m)
         MODE_DATA: mode_breach = is_fetch;
         MODE_BOTH: mode_breach = 1'b0;
         default:   mode_breach = !is_fetch;
      endcase
   endfunction

endpackage

// File: rtl/ecl_page_match.sv
module ecl_page_match #(
   parameter int ADDR_W   = 32,
   parameter int PAGE_LSB = 12,
   parameter int PAGE_MSB = 27
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] lo_addr,
   input  logic [ADDR_W-1:0] hi_addr,
   input  logic              enable,
   output logic              match
);
   localparam int PAGE_W = PAGE_MSB - PAGE_LSB + 1;

   logic [PAGE_W-1:0] pg, pg_lo, pg_hi;
   logic              win_ok;

   always_comb begin
      pg     = addr[PAGE_MSB:PAGE_LSB];
      pg_lo  = lo_addr[PAGE_MSB:PAGE_LSB];
      pg_hi  = hi_addr[PAGE_MSB:PAGE_LSB];
      win_ok = enable && (pg_hi > pg_lo);
      match  = win_ok && (pg >= pg_lo) && (pg <= pg_hi);
   end
endmodule

// File: rtl/ecl_prio_pick.sv
module ecl_prio_pick #(
   parameter int N    = 4,
   parameter int ID_W = 2
) (
   input  logic [N-1:0]    req,
   output logic            any,
   output logic [ID_W-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            any = 1'b1;
            idx = ID_W'(i);
         end
      end
   end
endmodule

// File: rtl/ecl_policy.sv
module ecl_policy
   import enc_cls_pkg::*;
#(
   parameter int N      = 4,
   parameter int MODE_W = 2
) (
   input  logic [N*MODE_W-1:0] modes,
   input  logic                is_fetch,
   output logic [N-1:0]        breach
);
   for (genvar g = 0; g < N; g++) begin : g_win
      assign breach[g] = mode_breach(win_mode_e'(modes[g*MODE_W +: MODE_W]), is_fetch);
   end
endmodule

// File: rtl/enc_region_classifier.sv
module enc_region_classifier #(
   parameter int NUM_REGIONS = 4,
   parameter int ADDR_W      = 32,
   parameter int PAGE_LSB    = 12,
   parameter int PAGE_MSB    = 27,
   parameter int MODE_W      = 2,
   localparam int ID_W       = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   input  logic [ADDR_W-1:0]             req_addr,
   input  logic                          req_fetch,
   input  logic [NUM_REGIONS*ADDR_W-1:0] cfg_start,
   input  logic [NUM_REGIONS*ADDR_W-1:0] cfg_end,
   input  logic [NUM_REGIONS-1:0]        cfg_en,
   input  logic [NUM_REGIONS*MODE_W-1:0] cfg_mode,
   input  logic                          err_clear,
   input  logic [ID_W-1:0]               rb_sel,
   output logic                          rd_hit,
   output logic [ID_W-1:0]               rd_region,
   output logic                          rd_zero,
   output logic                          viol_pulse,
   output logic                          viol_sticky,
   output logic [ADDR_W-1:0]             rb_start,
   output logic [ADDR_W-1:0]             rb_end
);
   localparam logic [ADDR_W-1:0] PAGE_KEEP =
      ((ADDR_W'(1) << (PAGE_MSB + 1)) - ADDR_W'(1)) & ~((ADDR_W'(1) << PAGE_LSB) - ADDR_W'(1));
   localparam logic [ADDR_W-1:0] OFFS_ONES = (ADDR_W'(1) << PAGE_LSB) - ADDR_W'(1);

   if (PAGE_MSB >= ADDR_W - 1 || PAGE_LSB < 1 || PAGE_MSB <= PAGE_LSB) begin : g_bad_page
      $error("enc_region_classifier: page field out of range");
   end
   if (MODE_W != 2) begin : g_bad_mode
      $error("enc_region_classifier: mode field must be two bits");
   end
   if (NUM_REGIONS < 1) begin : g_bad_num
      $error("enc_region_classifier: need at least one region");
   end

   logic [NUM_REGIONS-1:0] hit_vec;
   logic [NUM_REGIONS-1:0] breach_vec;
   logic                   any_hit;
   logic [ID_W-1:0]        win_idx;
   logic                   win_breach;

   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
      ecl_page_match #(
         .ADDR_W  (ADDR_W),
         .PAGE_LSB(PAGE_LSB),
         .PAGE_MSB(PAGE_MSB)
      ) u_match (
         .addr   (req_addr),
         .lo_addr(cfg_start[g*ADDR_W +: ADDR_W]),
         .hi_addr(cfg_end[g*ADDR_W +: ADDR_W]),
         .enable (cfg_en[g]),
         .match  (hit_vec[g])
      );
   end

   ecl_prio_pick #(.N(NUM_REGIONS), .ID_W(ID_W)) u_pick (
      .req(hit_vec),
      .any(any_hit),
      .idx(win_idx)
   );

   ecl_policy #(.N(NUM_REGIONS), .MODE_W(MODE_W)) u_policy (
      .modes   (cfg_mode),
      .is_fetch(req_fetch),
      .breach  (breach_vec)
   );

   always_comb begin
      win_breach = 1'b0;
      for (int i = 0; i < NUM_REGIONS; i++) begin
         if (win_idx == ID_W'(i)) win_breach = breach_vec[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_hit      <= 1'b0;
         rd_region   <= '0;
         rd_zero     <= 1'b0;
         viol_pulse  <= 1'b0;
         viol_sticky <= 1'b0;
      end else begin
         viol_pulse <= 1'b0;
         if (req_valid) begin
            rd_hit     <= any_hit;
            rd_region  <= any_hit ? win_idx : '0;
            rd_zero    <= any_hit && win_breach;
            viol_pulse <= any_hit && win_breach;
         end
         if (req_valid && any_hit && win_breach) viol_sticky <= 1'b1;
         else if (err_clear)                     viol_sticky <= 1'b0;
      end
   end

   always_comb begin
      rb_start = '0;
      rb_end   = OFFS_ONES;
      for (int i = 0; i < NUM_REGIONS; i++) begin
         if (rb_sel == ID_W'(i)) begin
            rb_start = cfg_start[i*ADDR_W +: ADDR_W] & PAGE_KEEP;
            rb_end   = (cfg_end[i*ADDR_W +: ADDR_W] & PAGE_KEEP) | OFFS_ONES;
         end
      end
   end
endmodule

// File: rtl/ecl_checker.sv
module ecl_checker #(
   parameter int ADDR_W   = 32,
   parameter int ID_W     = 2,
   parameter int PAGE_LSB = 12,
   parameter int PAGE_MSB = 27
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              err_clear,
   input logic              rd_hit,
   input logic [ID_W-1:0]   rd_region,
   input logic              rd_zero,
   input logic              viol_pulse,
   input logic              viol_sticky,
   input logic [ADDR_W-1:0] rb_start,
   input logic [ADDR_W-1:0] rb_end
);
   // R7
   zero_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_zero |-> rd_hit);

   // R7
   pulse_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      viol_pulse |-> rd_zero);

   // R8
   sticky_follows_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      viol_pulse |-> viol_sticky);

   // R8
   sticky_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(viol_sticky) |-> $past(err_clear));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(rd_hit) && $stable(rd_region) && $stable(rd_zero) && !viol_pulse));

   // R3
   miss_id_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit |-> (rd_region == '0));

   // R10
   always_comb begin
      if (rst_n) begin
         readback_mask_chk: assert (rb_start[PAGE_LSB-1:0] == '0 &&
                                    rb_end[PAGE_LSB-1:0] == '1 &&
                                    rb_start[ADDR_W-1:PAGE_MSB+1] == '0 &&
                                    rb_end[ADDR_W-1:PAGE_MSB+1] == '0);
      end
   end
endmodule

bind enc_region_classifier ecl_checker #(
   .ADDR_W  (ADDR_W),
   .ID_W    (ID_W),
   .PAGE_LSB(PAGE_LSB),
   .PAGE_MSB(PAGE_MSB)
) u_ecl_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .err_clear  (err_clear),
   .rd_hit     (rd_hit),
   .rd_region  (rd_region),
   .rd_zero    (rd_zero),
   .viol_pulse (viol_pulse),
   .viol_sticky(viol_sticky),
   .rb_start   (rb_start),
   .rb_end     (rb_end)
);

// File: tb/enc_region_classifier_bench.sv
module enc_region_classifier_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic [31:0]  req_addr = '0;
   logic         req_fetch = 1'b0;
   logic [127:0] cfg_start, cfg_end;
   logic [3:0]   cfg_en;
   logic [7:0]   cfg_mode;
   logic         err_clear = 1'b0;
   logic [1:0]   rb_sel = '0;
   logic         rd_hit, rd_zero, viol_pulse, viol_sticky;
   logic [1:0]   rd_region;
   logic [31:0]  rb_start, rb_end;

   logic [31:0] st [4];
   logic [31:0] en_a [4];
   logic [1:0]  md [4];
   logic [3:0]  ena = '0;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   assign cfg_start = {st[3], st[2], st[1], st[0]};
   assign cfg_end   = {en_a[3], en_a[2], en_a[1], en_a[0]};
   assign cfg_mode  = {md[3], md[2], md[1], md[0]};
   assign cfg_en    = ena;

   enc_region_classifier u_enc_region_classifier (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_fetch(req_fetch), .cfg_start(cfg_start), .cfg_end(cfg_end),
      .cfg_en(cfg_en), .cfg_mode(cfg_mode), .err_clear(err_clear), .rb_sel(rb_sel),
      .rd_hit(rd_hit), .rd_region(rd_region), .rd_zero(rd_zero),
      .viol_pulse(viol_pulse), .viol_sticky(viol_sticky),
      .rb_start(rb_start), .rb_end(rb_end)
   );

   // {addr, fetch, hit, id, zero}
   localparam logic [36:0] VEC [12] = '{
      {32'h0000_FFFF, 1'b0, 1'b0, 2'd0, 1'b0},
      {32'h0001_0000, 1'b0, 1'b1, 2'd0, 1'b0},
      {32'h0001_3FFF, 1'b1, 1'b1, 2'd0, 1'b0},
      {32'h0001_4000, 1'b0, 1'b0, 2'd0, 1'b0},
      {32'h0002_0010, 1'b1, 1'b1, 2'd1, 1'b1},
      {32'h0002_1FFC, 1'b0, 1'b1, 2'd1, 1'b0},
      {32'h0003_0000, 1'b0, 1'b1, 2'd2, 1'b1},
      {32'h0003_2FFF, 1'b1, 1'b1, 2'd2, 1'b0},
      {32'h0004_1000, 1'b0, 1'b1, 2'd3, 1'b1},
      {32'h0004_0000, 1'b1, 1'b1, 2'd3, 1'b0},
      {32'hF001_2000, 1'b0, 1'b1, 2'd0, 1'b0},
      {32'h0004_2000, 1'b1, 1'b0, 2'd0, 1'b0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic std_cfg();
      st[0] = 32'h0001_0000; en_a[0] = 32'h0001_3FFF; md[0] = 2'b10;
      st[1] = 32'h0002_0000; en_a[1] = 32'h0002_1FFF; md[1] = 2'b01;
      st[2] = 32'h0003_0000; en_a[2] = 32'h0003_2FFF; md[2] = 2'b00;
      st[3] = 32'h0004_0000; en_a[3] = 32'h0004_1FFF; md[3] = 2'b11;
      ena = 4'hF;
   endtask

   // one request; outputs sampled at the negedge after the capturing edge
   task automatic do_req(input logic [31:0] a, input logic f, input logic clr);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_fetch = f; err_clear = clr;
      @(negedge clk);
      req_valid = 1'b0; err_clear = 1'b0;
   endtask

   task automatic expect_res(input string req, input logic h, input logic [1:0] id, input logic z);
      check({req, " hit"},   {31'd0, rd_hit},     {31'd0, h});
      check({req, " id"},    {30'd0, rd_region},  {30'd0, id});
      check({req, " zero"},  {31'd0, rd_zero},    {31'd0, z});
      check({req, " pulse"}, {31'd0, viol_pulse}, {31'd0, z});
   endtask

   // reference model written from R1..R6
   task automatic model(input logic [31:0] a, input logic f,
                        output logic h, output logic [1:0] id, output logic z);
      h = 0; id = 0; z = 0;
      for (int i = 0; i < 4; i++) begin
         if (!h && ena[i] && en_a[i][27:12] > st[i][27:12] &&
             a[27:12] >= st[i][27:12] && a[27:12] <= en_a[i][27:12]) begin
            h = 1; id = 2'(i);
            z = (md[i] == 2'b01) ? f : (md[i] == 2'b10) ? 1'b0 : !f;
         end
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         summary();
         $finish;
      end
   end

   initial begin
      logic h, z;
      logic [1:0] id;
      std_cfg();
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11 hit",    {31'd0, rd_hit},      0);
      check("R11 sticky", {31'd0, viol_sticky}, 0);
      check("R11 pulse",  {31'd0, viol_pulse},  0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 zero after reset", {31'd0, rd_zero}, 0);

      // R1 R2 R5 R6 R7 table walk
      for (int v = 0; v < 12; v++) begin
         do_req(VEC[v][36:5], VEC[v][4], 1'b0);
         expect_res($sformatf("R1 vec%0d", v), VEC[v][3], VEC[v][2:1], VEC[v][0]);
      end
      check("R8 sticky set", {31'd0, viol_sticky}, 1);

      // R9 hold during idle
      do_req(32'h0004_1000, 1'b0, 1'b0);
      repeat (3) @(negedge clk);
      check("R9 hold hit",  {31'd0, rd_hit},     1);
      check("R9 hold id",   {30'd0, rd_region},  3);
      check("R9 hold zero", {31'd0, rd_zero},    1);
      check("R9 no pulse",  {31'd0, viol_pulse}, 0);

      // R8 clear, then clear together with violation
      err_clear = 1'b1; @(negedge clk); err_clear = 1'b0;
      check("R8 cleared", {31'd0, viol_sticky}, 0);
      do_req(32'h0002_0000, 1'b1, 1'b1);
      check("R8 set beats clear", {31'd0, viol_sticky}, 1);

      // R3 disabled window
      ena[0] = 1'b0;
      do_req(32'h0001_0000, 1'b0, 1'b0);
      expect_res("R3 disabled", 0, 0, 0);
      ena[0] = 1'b1;
      // R3 single-page and inverted windows
      en_a[1] = 32'h0002_0FFF;
      do_req(32'h0002_0000, 1'b0, 1'b0);
      expect_res("R3 single page", 0, 0, 0);
      en_a[1] = 32'h0001_0FFF;
      do_req(32'h0001_8000, 1'b0, 1'b0);
      expect_res("R3 inverted", 0, 0, 0);
      std_cfg();

      // R4 overlap priority
      st[2] = 32'h0001_2000; en_a[2] = 32'h0001_5FFF; md[2] = 2'b10;
      do_req(32'h0001_2000, 1'b1, 1'b0);
      expect_res("R4 low index wins", 1, 0, 0);
      do_req(32'h0001_5000, 1'b1, 1'b0);
      expect_res("R4 only upper", 1, 2, 0);
      ena[0] = 1'b0;
      do_req(32'h0001_2000, 1'b0, 1'b0);
      expect_res("R4 after disable", 1, 2, 0);
      std_cfg();

      // R10 readback masking, R2 ignored bound bits
      st[0] = 32'hF001_0ABC; en_a[0] = 32'hF001_3000; rb_sel = 2'd0;
      @(negedge clk);
      check("R10 start", rb_start, 32'h0001_0000);
      check("R10 end",   rb_end,   32'h0001_3FFF);
      do_req(32'h5001_3FF0, 1'b0, 1'b0);
      expect_res("R2 masked bounds", 1, 0, 0);
      rb_sel = 2'd3;
      @(negedge clk);
      check("R10 start sel3", rb_start, 32'h0004_0000);
      check("R10 end sel3",   rb_end,   32'h0004_1FFF);
      std_cfg();

      // R1 R5 R6 boundary sweep against the model
      for (int r = 0; r < 4; r++) begin
         for (int k = 0; k < 4; k++) begin
            for (int f = 0; f < 2; f++) begin
               logic [31:0] a;
               case (k)
                  0: a = st[r] - 32'd1;
                  1: a = st[r];
                  2: a = en_a[r];
                  default: a = en_a[r] + 32'd1;
               endcase
               model(a, f[0], h, id, z);
               do_req(a, f[0], 1'b0);
               expect_res($sformatf("R1 R5 R6 sweep r%0d k%0d f%0d", r, k, f), h, id, z);
            end
         end
      end

      done = 1;
      summary();
      $finish;
   end
endmodule